// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Frames

This block is where message-signalled interrupt writes end up. Every incoming message carries an address and a data word. The address picks one of 16 frames and one of 8 vector registers in that frame. The low four bits of the data pick one of 16 pending bits in that register. Taken together, this gives 2048 separately pending vectors.

Software reads the pending state through a simple read port, and reading a vector register clears it. Each frame also has a summary register. Each bit of the summary shows whether one of the frame's registers holds any pending bit, so an interrupt handler can find the busy registers without reading every one. Each frame drives its own interrupt line. The line stays high for as long as any register in that frame has a pending bit.

Address layout, 12 bits:
- Bit 11 selects the region: 0 for vector registers, 1 for summary registers.
- Bits [10:7] give the frame.
- Bits [6:4] give the register index, used in the vector region only.

A mapped vector address has bits [3:0] equal to zero. A mapped summary address has bits [6:0] equal to zero.

Top module: `msi_term_unit`

## Requirements
- R1: While rst_ni is low, all pending bits clear. After reset, irq_o is 0, and rd_data_o is 0 until a read is issued.
- R2: A message write to mapped vector address (frame f, register r) sets bit msg_data_i[3:0] of that register. Bits set earlier stay set, so pending bits accumulate as an OR.
- R3: Message data bits [31:4] have no effect on the bit that is set. rd_data_o bits [31:16] are always 0.
- R4: A read of a mapped vector register returns its 16 pending bits in rd_data_o[15:0] one cycle after rd_valid_i, and clears that register at the same clock edge.
- R5: A read of frame f's summary returns, in rd_data_o[7:0], a bit r set for each register r of frame f that is nonzero. The read has no side effect.
- R6: irq_o[f] is high exactly when some register of frame f is nonzero. It rises in the cycle after the setting write.
- R7: When a message write and a clearing read hit the same register in the same cycle, the read returns the contents from before that write, and the newly written bit stays pending.
- R8: Reads of unmapped addresses return 0. Message writes to unmapped addresses, meaning the summary region or nonzero low offset bits, change no state.
- R9: A write to one frame changes no other frame's registers or interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| msg_valid_i | input | 1 | Message write strobe |
| msg_addr_i | input | 12 | Message write address |
| msg_data_i | input | 32 | Message data; bits [3:0] select the vector |
| rd_valid_i | input | 1 | Register read strobe |
| rd_addr_i | input | 12 | Register read address |
| rd_data_o | output | 32 | Read data, valid one cycle after rd_valid_i, otherwise 0 |
| irq_o | output | 16 | One interrupt line per frame |

## Verification
The directed patterns each isolate one mechanism:
- A data word with junk in its upper bits shows that only the low nibble selects the vector.
- Two writes to the same register show that pending bits accumulate.
- A repeated summary read shows that summary reads have no side effect.
- Back-to-back reads of one vector register show that the first read clears it.
- A write and a read aimed at the same register in the same cycle show which of the two wins.
- Writes with nonzero offset bits, and reads into holes in the address map, show that unmapped accesses are dropped.

A long run of mixed random writes and reads, with addresses biased toward a few frames, is then compared every clock against a behavioural model. This exposes cross-frame leakage and wrong frame or index decoding.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  localparam int unsigned NUM_FRAMES = 16;
  localparam int unsigned REGS_PER_FRAME = 8;
  localparam int unsigned VEC_PER_REG = 16;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned FRAME_W = $clog2(NUM_FRAMES);
  localparam int unsigned REG_W = $clog2(REGS_PER_FRAME);
  localparam int unsigned VEC_W = $clog2(VEC_PER_REG);
  localparam int unsigned REG_LSB = VEC_W;
  localparam int unsigned FRAME_LSB = REG_LSB + REG_W;
  localparam int unsigned REGION_BIT = FRAME_LSB + FRAME_W;
  localparam int unsigned ADDR_W = REGION_BIT + 1;

  typedef struct packed {
    logic               vec_hit;
    logic               sum_hit;
    logic [FRAME_W-1:0] frame;
    logic [REG_W-1:0]   idx;
  } dec_t;
endpackage

// File: rtl/msi_addr_dec.sv
module msi_addr_dec
  import msi_term_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.frame   = addr_i[FRAME_LSB +: FRAME_W];
    dec_o.idx     = addr_i[REG_LSB +: REG_W];
    dec_o.vec_hit = !addr_i[REGION_BIT] && (addr_i[REG_LSB-1:0] == '0);
    dec_o.sum_hit = addr_i[REGION_BIT] && (addr_i[FRAME_LSB-1:0] == '0);
  end
endmodule

// File: rtl/msi_frame.sv
module msi_frame
  import msi_term_pkg::*;
(
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       set_en_i,
  input  logic [REG_W-1:0]                           set_idx_i,
  input  logic [VEC_W-1:0]                           set_vec_i,
  input  logic                                       clr_en_i,
  input  logic [REG_W-1:0]                           clr_idx_i,
  output logic [REGS_PER_FRAME-1:0][VEC_PER_REG-1:0] vec_o,
  output logic [REGS_PER_FRAME-1:0]                  sum_o,
  output logic                                       irq_o
);
  logic [VEC_PER_REG-1:0] set_mask;
  assign set_mask = VEC_PER_REG'(1) << set_vec_i;

  for (genvar g = 0; g < REGS_PER_FRAME; g++) begin : g_reg
    logic set_hit, clr_hit;
    assign set_hit = set_en_i && (set_idx_i == REG_W'(g));
    assign clr_hit = clr_en_i && (clr_idx_i == REG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vec_o[g] <= '0;
      end else if (set_hit || clr_hit) begin
        // a write landing with a clearing read survives the clear
        vec_o[g] <= (clr_hit ? '0 : vec_o[g]) | (set_hit ? set_mask : '0);
      end
    end

    assign sum_o[g] = |vec_o[g];
  end

  assign irq_o = |sum_o;
endmodule

// File: rtl/msi_term_unit.sv
module msi_term_unit
  import msi_term_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [ADDR_W-1:0] msg_addr_i,
  input  logic [DATA_W-1:0] msg_data_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_FRAMES-1:0] irq_o
);
  dec_t wr_dec, rd_dec;
  logic [NUM_FRAMES-1:0][REGS_PER_FRAME-1:0][VEC_PER_REG-1:0] vec_all;
  logic [NUM_FRAMES-1:0][REGS_PER_FRAME-1:0]                  sum_all;
  logic [DATA_W-1:0] rd_next;

  msi_addr_dec u_wr_dec (.addr_i(msg_addr_i), .dec_o(wr_dec));
  msi_addr_dec u_rd_dec (.addr_i(rd_addr_i),  .dec_o(rd_dec));

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    logic set_en, clr_en;
    assign set_en = msg_valid_i && wr_dec.vec_hit && (wr_dec.frame == FRAME_W'(f));
    assign clr_en = rd_valid_i && rd_dec.vec_hit && (rd_dec.frame == FRAME_W'(f));

    msi_frame u_frame (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_en_i  (set_en),
      .set_idx_i (wr_dec.idx),
      .set_vec_i (msg_data_i[VEC_W-1:0]),
      .clr_en_i  (clr_en),
      .clr_idx_i (rd_dec.idx),
      .vec_o     (vec_all[f]),
      .sum_o     (sum_all[f]),
      .irq_o     (irq_o[f])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_valid_i) begin
      if (rd_dec.vec_hit)      rd_next[VEC_PER_REG-1:0]    = vec_all[rd_dec.frame][rd_dec.idx];
      else if (rd_dec.sum_hit) rd_next[REGS_PER_FRAME-1:0] = sum_all[rd_dec.frame];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_next;
  end
endmodule

// File: rtl/msi_term_chk.sv
module msi_term_chk
  import msi_term_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  msg_valid_i,
  input logic [ADDR_W-1:0]     msg_addr_i,
  input logic [DATA_W-1:0]     msg_data_i,
  input logic                  rd_valid_i,
  input logic [ADDR_W-1:0]     rd_addr_i,
  input logic [DATA_W-1:0]     rd_data_o,
  input logic [NUM_FRAMES-1:0] irq_o
);
  logic wr_map, rd_map, rd_sum;
  logic [FRAME_W-1:0] wr_frame, rd_frame;
  assign wr_map   = !msg_addr_i[ADDR_W-1] && (msg_addr_i[VEC_W-1:0] == '0);
  assign rd_sum   = rd_addr_i[ADDR_W-1] && (rd_addr_i[VEC_W+REG_W-1:0] == '0);
  assign rd_map   = rd_sum || (!rd_addr_i[ADDR_W-1] && (rd_addr_i[VEC_W-1:0] == '0));
  assign wr_frame = msg_addr_i[ADDR_W-2 -: FRAME_W];
  assign rd_frame = rd_addr_i[ADDR_W-2 -: FRAME_W];

  AST_WR_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && wr_map) |=> irq_o[$past(wr_frame)]); // R6
  AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !rd_map) |=> (rd_data_o == '0)); // R8
  AST_IRQ_RISE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_o & ~$past(irq_o))) |-> $past(msg_valid_i)); // R6
  AST_IRQ_FALL_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(irq_o) & ~irq_o)) |-> $past(rd_valid_i)); // R4
  AST_SUM_RD_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_sum && irq_o[rd_frame]) |=> irq_o[$past(rd_frame)]); // R5
  AST_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:VEC_PER_REG] == '0); // R3
endmodule

bind msi_term_unit msi_term_chk u_chk (.*);

// File: tb/tb_msi_term_unit.sv
`timescale 1ns/1ps
module tb_msi_term_unit;
  import msi_term_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic msg_valid_i = 1'b0;
  logic [ADDR_W-1:0] msg_addr_i = '0;
  logic [DATA_W-1:0] msg_data_i = '0;
  logic rd_valid_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic [NUM_FRAMES-1:0] irq_o;

  always #2.5 clk_i = ~clk_i;

  msi_term_unit dut (.*);

  int checks = 0;
  int fails = 0;
  logic [15:0] m_vec [16][8];
  logic [31:0] exp_rd;
  logic [15:0] exp_irq;

  function automatic logic [11:0] vaddr(input int f, input int r);
    return {1'b0, 4'(f), 3'(r), 4'h0};
  endfunction
  function automatic logic [11:0] saddr(input int f);
    return {1'b1, 4'(f), 7'h0};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input logic mv, input logic [11:0] ma, input logic [31:0] md,
                       input logic rv, input logic [11:0] ra, input string tag);
    @(negedge clk_i);
    msg_valid_i = mv; msg_addr_i = ma; msg_data_i = md;
    rd_valid_i = rv; rd_addr_i = ra;
    @(posedge clk_i);
    exp_rd = '0;
    if (rv) begin
      if (!ra[11] && ra[3:0] == 0) begin
        exp_rd[15:0] = m_vec[ra[10:7]][ra[6:4]];
        m_vec[ra[10:7]][ra[6:4]] = '0;
      end else if (ra[11] && ra[6:0] == 0) begin
        for (int r = 0; r < 8; r++) exp_rd[r] = (m_vec[ra[10:7]][r] != 0);
      end
    end
    if (mv && !ma[11] && ma[3:0] == 0)
      m_vec[ma[10:7]][ma[6:4]][md[3:0]] = 1'b1;
    exp_irq = '0;
    for (int f = 0; f < 16; f++)
      for (int r = 0; r < 8; r++)
        if (m_vec[f][r] != 0) exp_irq[f] = 1'b1;
    #1;
    chk(tag, "rd_data_o", rd_data_o, exp_rd);
    chk(tag, "irq_o", 32'(irq_o), 32'(exp_irq));
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cycle(1'b0, '0, '0, 1'b1, a, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cycle(1'b1, a, d, 1'b0, '0, tag);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int f = 0; f < 16; f++) for (int r = 0; r < 8; r++) m_vec[f][r] = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1", "irq_o in reset", 32'(irq_o), 0);
    chk("R1", "rd_data_o in reset", rd_data_o, 0);
    rst_ni = 1'b1;
    rd(saddr(0), "R1");
    rd(vaddr(7, 3), "R1");

    wr(vaddr(3, 5), 32'hABCD_0009, "R3");
    rd(saddr(3), "R5");
    rd(saddr(3), "R5");
    rd(vaddr(3, 5), "R4");
    chk("R4", "read value", rd_data_o, 32'h0000_0200);
    rd(vaddr(3, 5), "R4");
    chk("R4", "cleared", rd_data_o, 0);

    wr(vaddr(0, 0), 32'h0, "R2");
    wr(vaddr(0, 0), 32'hF, "R2");
    rd(vaddr(0, 0), "R2");
    chk("R2", "accumulate", rd_data_o, 32'h0000_8001);

    wr(vaddr(15, 7), 32'h3, "R6");
    chk("R6", "irq frame 15", 32'(irq_o), 32'h8000);
    wr(vaddr(15, 2), 32'h1, "R6");
    rd(vaddr(15, 7), "R6");
    chk("R6", "irq held by other reg", 32'(irq_o), 32'h8000);
    rd(vaddr(15, 2), "R6");
    chk("R6", "irq dropped", 32'(irq_o), 0);

    wr(vaddr(2, 1), 32'h4, "R7");
    cycle(1'b1, vaddr(2, 1), 32'h7, 1'b1, vaddr(2, 1), "R7");
    chk("R7", "read old", rd_data_o, 32'h10);
    rd(vaddr(2, 1), "R7");
    chk("R7", "new bit kept", rd_data_o, 32'h80);

    wr(vaddr(4, 0) | 12'h001, 32'h3, "R8");
    wr(saddr(4), 32'h3, "R8");
    chk("R8", "irq after unmapped writes", 32'(irq_o), 0);
    rd(saddr(4), "R8");
    rd(vaddr(4, 0) | 12'h008, "R8");
    rd(12'hC01, "R8");
    chk("R8", "unmapped read", rd_data_o, 0);

    wr(vaddr(0, 7), 32'h5, "R9");
    chk("R9", "only frame 0", 32'(irq_o), 32'h1);
    rd(saddr(1), "R9");
    rd(vaddr(0, 7), "R9");

    for (int i = 0; i < 4000; i++) begin
      logic [11:0] wa, ra;
      wa = {1'b0, 4'($urandom_range(0, 3) * 5), 3'($urandom), ($urandom % 8 == 0) ? 4'($urandom) : 4'h0};
      if ($urandom % 10 == 0) wa[11] = 1'b1;
      ra = ($urandom % 4 == 0) ? saddr($urandom_range(0, 3) * 5)
                               : {1'b0, 4'($urandom_range(0, 3) * 5), 3'($urandom), 4'h0};
      if ($urandom % 12 == 0) ra = 12'($urandom);
      cycle(1'($urandom), wa, $urandom, 1'($urandom), ra, "R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule